// File: doc/BRIEF.md
# Inter-processor mailbox channel controller

The block gives several processors a shared set of mailbox channels for exchanging short messages and interrupts over a simple 32-bit register bus. Each channel occupies a 64-byte window: channel n starts at byte address n*0x40. A sender first claims a channel by writing its own one-hot bit into the channel's owner register and reading it back. It then picks the interrupt lines to raise, sets the interrupt enables and the mode, writes an eight-word message and fires the send. The receiving side sees a destination interrupt. In automatic-acknowledge mode the channel reports completion back to the sender on a second vector.

A global lock protects the register file. Writing a key value opens it. Any other value written to the same address closes it again. While the lock is closed, no channel register can be changed, but every register can still be read. Reads are registered: the value appears on the read port one clock after the read strobe.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset the lock reads 1, every channel's mode word reads 0x10 (idle bit 4 set, acknowledge bit 7 clear, auto bit 0 clear), every owner register reads 0, and both interrupt vectors are 0.
- R2: A write of 0x1ACCE551 to byte address 0xA00 makes that address read 0 from the next cycle. A write of any other value there makes it read 1.
- R3: While the lock reads 1, writes to any channel register leave it unchanged; reads still return the stored value.
- R4: Word offset 0x00 is the owner register. A write of a one-hot value to it takes effect only while it is 0 and clears the idle bit 4 of the mode word at 0x10. A write of a non-one-hot nonzero value, or any nonzero write while the channel is owned, is ignored.
- R5: Writing 0 to the owner register releases the channel: the idle bit returns to 1, the acknowledge bit 7 clears and the channel's bits leave the acknowledge vector.
- R6: A write to offset 0x04 sets the written bits in the destination set. A write to 0x08 clears them. Offset 0x0C reads the set.
- R7: Offsets 0x20 to 0x3C hold eight message words per channel that read back as written, independently for each channel.
- R8: A write to offset 0x1C that contains the owner bit, on an owned channel that has not yet sent, copies the destination set into the channel's pending bits. Other writes there are ignored. Output dst_irq_o bit j is 1 when some channel has pending bit j set and its enable mask (offset 0x14, reset all ones) has bit j at 0.
- R9: Offset 0x18 reads the pending bits. A write there clears every pending bit written as 1.
- R10: Mode bit 0 (offset 0x10) selects automatic acknowledge. With it set, acknowledge bit 7 rises one cycle after the send and ack_irq_o then carries the owner bit. With it clear, no acknowledge occurs.
- R11: rdata_o changes only on a clock edge where rd_i is high, and then shows the addressed register as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| dst_irq_o | output | 32 | Destination interrupt lines, enabled pending bits of all channels |
| ack_irq_o | output | 32 | Completion lines, owner bits of all acknowledged channels |

## Verification
A wrong owner or sent state appears on the read port at the next read of offset 0x00 or 0x10. If the owner bit is wrong, ack_irq_o carries the wrong bit one cycle after the send. A wrong pending or mask state shows on dst_irq_o in the cycle right after the send or clear write, with no further delay. A lock that opens or closes wrongly is exposed by the next channel write, which either sticks when it should be dropped or is dropped when it should stick, and this is visible at the following read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [31:0] LOCK_KEY = 32'h1ACCE551;
  localparam int MODE_AUTO_BIT = 0;
  localparam int MODE_IDLE_BIT = 4;
  localparam int MODE_ACK_BIT  = 7;
  localparam int MSG_WORDS     = 8;
  localparam int WIN_BYTES     = 64;

  // register word index inside a channel window (bit 3 = message words)
  typedef enum logic [2:0] {
    RG_SRC   = 3'd0,
    RG_DST   = 3'd1,
    RG_DCLR  = 3'd2,
    RG_DSTAT = 3'd3,
    RG_MODE  = 3'd4,
    RG_MASK  = 3'd5,
    RG_ICLR  = 3'd6,
    RG_SEND  = 3'd7
  } reg_e;
endpackage

// File: rtl/mbx_lock.sv
module mbx_lock
  import mbx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          unlocked_o
);
  logic unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) unlocked_q <= 1'b0;
    else if (we_i) unlocked_q <= (wdata_i == DW'(LOCK_KEY));
  end

  assign unlocked_o = unlocked_q;
endmodule

// File: rtl/mbx_chan.sv
module mbx_chan
  import mbx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [3:0]    woff_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [3:0]    roff_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_irq_o,
  output logic [DW-1:0] ack_irq_o,
  output logic          sent_o,
  output logic          ack_o
);
  localparam int WSEL_W = $clog2(MSG_WORDS);

  logic [DW-1:0] src_q, dst_q, pend_q, mask_q;
  logic          auto_q, sent_q, ack_q;
  logic [MSG_WORDS-1:0][DW-1:0] data_q;

  logic wr_reg, wr_msg, is_onehot, owned, send_ok;
  reg_e wsel, rsel;

  assign wr_reg    = we_i && !woff_i[3];
  assign wr_msg    = we_i && woff_i[3];
  assign wsel      = reg_e'(woff_i[2:0]);
  assign rsel      = reg_e'(roff_i[2:0]);
  assign owned     = (src_q != '0);
  assign is_onehot = (wdata_i != '0) && ((wdata_i & (wdata_i - DW'(1))) == '0);
  assign send_ok   = owned && ((wdata_i & src_q) != '0) && !sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      pend_q <= '0;
      mask_q <= '1;
      auto_q <= 1'b0;
      sent_q <= 1'b0;
      ack_q  <= 1'b0;
      data_q <= '0;
    end else begin
      if (sent_q && auto_q) ack_q <= 1'b1;
      if (wr_reg) begin
        case (wsel)
          RG_SRC: begin
            if (wdata_i == '0) begin
              src_q  <= '0;
              sent_q <= 1'b0;
              ack_q  <= 1'b0;
            end else if (!owned && is_onehot) begin
              src_q <= wdata_i;
            end
          end
          RG_DST:  dst_q  <= dst_q | wdata_i;
          RG_DCLR: dst_q  <= dst_q & ~wdata_i;
          RG_MODE: auto_q <= wdata_i[MODE_AUTO_BIT];
          RG_MASK: mask_q <= wdata_i;
          RG_ICLR: pend_q <= pend_q & ~wdata_i;
          RG_SEND: begin
            if (send_ok) begin
              pend_q <= pend_q | dst_q;
              sent_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (wr_msg) data_q[woff_i[WSEL_W-1:0]] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (roff_i[3]) begin
      rdata_o = data_q[roff_i[WSEL_W-1:0]];
    end else begin
      case (rsel)
        RG_SRC:   rdata_o = src_q;
        RG_DST,
        RG_DSTAT: rdata_o = dst_q;
        RG_MODE: begin
          rdata_o[MODE_AUTO_BIT] = auto_q;
          rdata_o[MODE_IDLE_BIT] = !owned;
          rdata_o[MODE_ACK_BIT]  = ack_q;
        end
        RG_MASK:  rdata_o = mask_q;
        RG_ICLR:  rdata_o = pend_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  assign src_o     = src_q;
  assign sent_o    = sent_q;
  assign ack_o     = ack_q;
  assign dst_irq_o = pend_q & ~mask_q;
  assign ack_irq_o = ack_q ? src_q : '0;
endmodule

// File: rtl/mbx_irq_merge.sv
module mbx_irq_merge #(
  parameter int NUM_CH = 32,
  parameter int DW     = 32
) (
  input  logic [NUM_CH-1:0][DW-1:0] dst_i,
  input  logic [NUM_CH-1:0][DW-1:0] ack_i,
  output logic [DW-1:0]             dst_o,
  output logic [DW-1:0]             ack_o
);
  always_comb begin
    dst_o = '0;
    ack_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      dst_o = dst_o | dst_i[c];
      ack_o = ack_o | ack_i[c];
    end
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int                NUM_CH    = 32,
  parameter int                DW        = 32,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'hA00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [DW-1:0]     dst_irq_o,
  output logic [DW-1:0]     ack_irq_o
);
  localparam int                CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int                WIN_LSB = $clog2(WIN_BYTES);
  localparam logic [ADDR_W:0]   WIN_END = (ADDR_W+1)'(NUM_CH * WIN_BYTES);

  logic            unlocked, in_win, is_lock;
  logic [CH_W-1:0] ch_sel;
  logic [3:0]      woff;
  logic [DW-1:0]   rdata_d, rdata_q;
  logic            unused_lsb;

  logic [NUM_CH-1:0][DW-1:0] ch_rdata, ch_src, ch_dirq, ch_airq;
  logic [NUM_CH-1:0]         ch_sent, ch_ack;

  assign in_win     = ({1'b0, addr_i} < WIN_END);
  assign is_lock    = (addr_i == LOCK_ADDR);
  assign ch_sel     = addr_i[WIN_LSB +: CH_W];
  assign woff       = addr_i[WIN_LSB-1:2];
  assign unused_lsb = ^addr_i[1:0];

  mbx_lock #(.DW(DW)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (we_i && is_lock),
    .wdata_i    (wdata_i),
    .unlocked_o (unlocked)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mbx_chan #(.DW(DW)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (we_i && unlocked && in_win && (ch_sel == CH_W'(g))),
      .woff_i    (woff),
      .wdata_i   (wdata_i),
      .roff_i    (woff),
      .rdata_o   (ch_rdata[g]),
      .src_o     (ch_src[g]),
      .dst_irq_o (ch_dirq[g]),
      .ack_irq_o (ch_airq[g]),
      .sent_o    (ch_sent[g]),
      .ack_o     (ch_ack[g])
    );
  end

  mbx_irq_merge #(.NUM_CH(NUM_CH), .DW(DW)) u_merge (
    .dst_i (ch_dirq),
    .ack_i (ch_airq),
    .dst_o (dst_irq_o),
    .ack_o (ack_irq_o)
  );

  always_comb begin
    rdata_d = '0;
    if (is_lock)     rdata_d = DW'(!unlocked);
    else if (in_win) rdata_d = ch_rdata[ch_sel];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ipc_mailbox_chk.sv
module ipc_mailbox_chk
  import mbx_pkg::*;
#(
  parameter int                NUM_CH    = 32,
  parameter int                DW        = 32,
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 12'hA00
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      we_i,
  input logic                      rd_i,
  input logic [ADDR_W-1:0]         addr_i,
  input logic [DW-1:0]             wdata_i,
  input logic [DW-1:0]             rdata_o,
  input logic                      unlocked,
  input logic [NUM_CH-1:0][DW-1:0] ch_src,
  input logic [NUM_CH-1:0]         ch_sent,
  input logic [NUM_CH-1:0]         ch_ack
);
  p_key_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == LOCK_ADDR && wdata_i == DW'(LOCK_KEY)) |=> unlocked);

  p_other_closes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == LOCK_ADDR && wdata_i != DW'(LOCK_KEY)) |=> !unlocked);

  p_rd_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_locked_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !unlocked |=> $stable(ch_src[g]));

    p_owner_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(ch_src[g]));

    p_ack_only_sent_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_ack[g] |-> ch_sent[g]);

    p_ack_after_send_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ch_ack[g]) |-> $past(ch_sent[g]));
  end
endmodule

bind ipc_mailbox ipc_mailbox_chk #(
  .NUM_CH(NUM_CH), .DW(DW), .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .rd_i     (rd_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .unlocked (unlocked),
  .ch_src   (ch_src),
  .ch_sent  (ch_sent),
  .ch_ack   (ch_ack)
);

// File: tb/ipc_mailbox_tb.sv
`timescale 1ns/1ps
module ipc_mailbox_tb;
  localparam int NV = 39;
  localparam logic [2:0] OP_W = 3'd0, OP_R = 3'd1, OP_DST = 3'd2, OP_ACK = 3'd3, OP_NOP = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [11:0] addr;
    logic [31:0] val;
    logic [7:0]  req;
  } vec_t;

  // main flow on channel 3 (window 0xC0)
  localparam vec_t VECS [NV] = '{
    '{OP_R,   12'hA00, 32'h1,        8'd1},  // R1 lock closed
    '{OP_R,   12'h0D0, 32'h10,       8'd1},  // R1 idle
    '{OP_W,   12'h0C0, 32'h4,        8'd3},  // R3 write while locked
    '{OP_R,   12'h0C0, 32'h0,        8'd3},  // R3
    '{OP_W,   12'hA00, 32'h1ACCE551, 8'd2},
    '{OP_R,   12'hA00, 32'h0,        8'd2},  // R2
    '{OP_W,   12'h0C0, 32'h4,        8'd4},  // claim
    '{OP_R,   12'h0C0, 32'h4,        8'd4},  // R4
    '{OP_R,   12'h0D0, 32'h0,        8'd4},  // R4 idle cleared
    '{OP_W,   12'h0C0, 32'h8,        8'd4},  // second claim
    '{OP_R,   12'h0C0, 32'h4,        8'd4},  // R4 refused
    '{OP_W,   12'h0D4, 32'hFFFFFFDF, 8'd8},
    '{OP_W,   12'h0C4, 32'h120,      8'd6},
    '{OP_W,   12'h0C8, 32'h100,      8'd6},
    '{OP_R,   12'h0CC, 32'h20,       8'd6},  // R6
    '{OP_W,   12'h0D0, 32'h1,        8'd10},
    '{OP_W,   12'h0E0, 32'h11111111, 8'd7},
    '{OP_W,   12'h0FC, 32'h88888888, 8'd7},
    '{OP_R,   12'h0E0, 32'h11111111, 8'd7},  // R7
    '{OP_R,   12'h0FC, 32'h88888888, 8'd7},  // R7
    '{OP_DST, 12'h000, 32'h0,        8'd8},  // R8 no send yet
    '{OP_W,   12'h0DC, 32'h8,        8'd8},  // send without owner bit
    '{OP_DST, 12'h000, 32'h0,        8'd8},  // R8 ignored
    '{OP_W,   12'h0DC, 32'h4,        8'd8},  // send
    '{OP_DST, 12'h000, 32'h20,       8'd8},  // R8
    '{OP_ACK, 12'h000, 32'h0,        8'd10}, // R10 not yet
    '{OP_NOP, 12'h000, 32'h0,        8'd10},
    '{OP_ACK, 12'h000, 32'h4,        8'd10}, // R10
    '{OP_R,   12'h0D0, 32'h81,       8'd10}, // R10
    '{OP_R,   12'h0D8, 32'h20,       8'd9},  // R9
    '{OP_W,   12'h0D8, 32'h20,       8'd9},
    '{OP_DST, 12'h000, 32'h0,        8'd9},  // R9
    '{OP_W,   12'h0C0, 32'h0,        8'd5},  // release
    '{OP_R,   12'h0D0, 32'h11,       8'd5},  // R5
    '{OP_ACK, 12'h000, 32'h0,        8'd5},  // R5
    '{OP_W,   12'hA00, 32'h0,        8'd2},
    '{OP_R,   12'hA00, 32'h1,        8'd2},  // R2
    '{OP_W,   12'h0C0, 32'h4,        8'd3},
    '{OP_R,   12'h0C0, 32'h0,        8'd3}   // R3
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0, rd_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, dst_irq_o, ack_irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  ipc_mailbox u_dut (
    .clk_i, .rst_ni, .we_i, .rd_i, .addr_i, .wdata_i,
    .rdata_o, .dst_irq_o, .ack_irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic apply_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    logic [31:0] v;
    apply_reset();
    chk("R1 dst_irq", dst_irq_o, 32'h0);
    chk("R1 ack_irq", ack_irq_o, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_W:   wr(VECS[i].addr, VECS[i].val);
        OP_R: begin
          rd(VECS[i].addr, v);
          chk($sformatf("R%0d read %h", VECS[i].req, VECS[i].addr), v, VECS[i].val);
        end
        OP_DST: chk($sformatf("R%0d dst_irq", VECS[i].req), dst_irq_o, VECS[i].val);
        OP_ACK: chk($sformatf("R%0d ack_irq", VECS[i].req), ack_irq_o, VECS[i].val);
        default: @(negedge clk_i);
      endcase
    end

    // R11: read data moves only on the strobed edge
    wr(12'hA00, 32'h1ACCE551);
    rd(12'h0C0, v);
    chk("R11 base", v, 32'h0);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = 12'h0D0;
    #1;
    chk("R11 before edge", rdata_o, 32'h0);
    @(negedge clk_i);
    rd_i = 1'b0;
    chk("R11 after edge", rdata_o, 32'h11);

    // channel 0 without automatic acknowledge
    wr(12'h000, 32'h1);
    wr(12'h004, 32'h2);
    wr(12'h014, 32'h0);
    wr(12'h01C, 32'h1);
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10 no ack in manual mode", ack_irq_o, 32'h0);
    chk("R8 unmasked line", dst_irq_o, 32'h2);
    rd(12'h010, v);
    chk("R10 mode word manual", v, 32'h0);
    wr(12'h014, 32'hFFFFFFFF);
    chk("R8 masked line", dst_irq_o, 32'h0);

    // R4: non-one-hot claim on channel 1
    wr(12'h040, 32'h3);
    rd(12'h040, v);
    chk("R4 non-one-hot claim", v, 32'h0);

    // R7: message words are per channel
    rd(12'h060, v);
    chk("R7 other channel untouched", v, 32'h0);
    rd(12'h0E0, v);
    chk("R7 channel 3 kept", v, 32'h11111111);

    // R1: reset again mid-run
    apply_reset();
    chk("R1 dst_irq after reset", dst_irq_o, 32'h0);
    chk("R1 ack_irq after reset", ack_irq_o, 32'h0);
    rd(12'hA00, v);
    chk("R1 lock after reset", v, 32'h1);
    rd(12'h000, v);
    chk("R1 owner after reset", v, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule